// File: doc/BRIEF.md
# Bipolar Line Decoder with Substitution Removal and Alarm Detection

This block is the receive side of a bipolar line interface. A front end outside the block slices the ternary line signal into two unipolar rails, one for positive marks and one for negative marks. A clock recovered outside the block is also supplied. The block turns these rails back into unipolar NRZ data. In HDB3 mode it removes the zero-substitution patterns that the far-end encoder inserted. In AMI mode it decodes plain alternate mark inversion. In both modes it flags line code errors on a dedicated output.

An alarm detector watches for an all-ones condition. A line that carries fewer than the minimum number of zeros in a fixed window of bit periods raises a sticky alarm flag. Only the alarm clear input lowers that flag. A loop test input makes the decoder take the local encoder's two rail outputs in place of the external line rails, so the transmit and receive paths can be tested back to back.

Decoding works as follows. A mark with the same polarity as the last mark is a bipolar violation. In HDB3 mode the violation is decoded as a zero. The mark three bit positions before it is also cleared, because that mark is the balancing pulse of a B00V substitution. A three-stage data delay line makes this backward clearing possible, and it gives the decoder a fixed latency.

Top module: `line_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `nrz_out`, `code_err` and `alarm_flag` are all 0 after that edge.
- R2: The rails are sampled at a rising edge, and the decoded bit appears on `nrz_out` four rising edges later. A mark on exactly one rail decodes to 1. No mark decodes to 0. A mark that alternates in polarity is never an error. The first mark after reset is never a violation.
- R3: In HDB3 mode (`mode_hdb3` = 1), a violation preceded by three empty positions (000V) decodes as four zeros, with no error.
- R4: In HDB3 mode, a violation at position t decodes as 0 and also forces position t-3 to 0. This means B00V decodes as four zeros. The sequence is valid and raises no error.
- R5: In AMI mode (`mode_hdb3` = 0), two successive marks of the same polarity raise `code_err` for one bit period. The bit is sampled at rising edge k, and the flag is high after edge k+1. The violating mark still decodes to 1, and no earlier bit is cleared.
- R6: In HDB3 mode, a violation with a mark at position t-1 or t-2 raises `code_err` for one bit period, with the same timing as R5. The violation itself decodes to 0.
- R7: Both rails high in the same bit period decodes to 0 and raises `code_err` for one bit period. It does not change the polarity remembered for violation checking.
- R8: The alarm window restarts at the edge that samples `alarm_clr`. At the end of each window of WIN sampled bit periods (default 512), the detector checks the number of no-mark periods it counted. If that count is below ZMIN (default 3), `alarm_flag` rises. With `alarm_clr` sampled at edge X, the first window covers the rail samples taken at edges X to X+511, and the flag rises after edge X+512.
- R9: Once set, `alarm_flag` stays high whatever the line carries, until `alarm_clr` is sampled high. It is low after that edge.
- R10: With `loop_en` high, the decoder takes `lb_pos`/`lb_neg` and ignores `rx_pos`/`rx_neg`. With `loop_en` low, it takes the external rails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_hdb3 | input | 1 | 1 = HDB3 decoding, 0 = AMI decoding |
| loop_en | input | 1 | 1 = decode the local encoder rails |
| rx_pos | input | 1 | External positive-mark rail |
| rx_neg | input | 1 | External negative-mark rail |
| lb_pos | input | 1 | Local encoder positive-mark rail |
| lb_neg | input | 1 | Local encoder negative-mark rail |
| alarm_clr | input | 1 | Clears the alarm flag and restarts its window |
| nrz_out | output | 1 | Decoded unipolar NRZ data |
| code_err | output | 1 | One-period pulse per detected code error |
| alarm_flag | output | 1 | Sticky all-ones alarm |

## Verification
The hardest case to reach is the alarm threshold boundary. The flag depends on zeros counted across 512 consecutive bit periods, and the window phase is set only by the alarm clear. The stimulus therefore pulses the clear first. It then holds an alternating-mark stream and places exactly two or exactly three zeros at known offsets. The flag is sampled on the cycle just before and the cycle just after the window closes. The backward clearing of B00V is reached by resetting the polarity memory, so that the balancing pulse and the violation land exactly three positions apart.

// File: rtl/line_dec_pkg.sv
package line_dec_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;

  function automatic logic rail_empty(rail_t r);
    return !(r.pos || r.neg);
  endfunction

endpackage

// File: rtl/ld_front.sv
module ld_front
  import line_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  loop_en,
  input  rail_t ext_in,
  input  rail_t lb_in,
  output rail_t smp
);

  always_ff @(posedge clk) begin
    if (rst) smp <= '0;
    else     smp <= loop_en ? lb_in : ext_in;
  end

  p_loop_path_r10: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> (smp == $past(lb_in)));

  p_ext_path_r10: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> (smp == $past(ext_in)));

endmodule

// File: rtl/ld_core.sv
module ld_core
  import line_dec_pkg::*;
#(
  parameter int SUB_LEN = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  mode_hdb3,
  input  rail_t smp,
  output logic  nrz_out,
  output logic  code_err
);

  localparam int DLY = SUB_LEN - 1;

  logic           last_pos;
  logic           have_prev;
  logic [DLY-1:0] raw_q;
  logic [DLY-1:0] dl_q;

  logic one_mark, both, viol, sub_ok, bit_in, drop_now;

  always_comb begin
    one_mark = smp.pos ^ smp.neg;
    both     = smp.pos & smp.neg;
    viol     = one_mark && have_prev && (smp.pos == last_pos);
    sub_ok   = (raw_q[DLY-2:0] == '0);
    drop_now = mode_hdb3 && viol;
    bit_in   = one_mark && !drop_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pos  <= 1'b0;
      have_prev <= 1'b0;
    end else if (one_mark) begin
      last_pos  <= smp.pos;
      have_prev <= 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DLY; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) begin
            dl_q[0]  <= 1'b0;
            raw_q[0] <= 1'b0;
          end else begin
            dl_q[0]  <= bit_in;
            raw_q[0] <= smp.pos | smp.neg;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) begin
            dl_q[g]  <= 1'b0;
            raw_q[g] <= 1'b0;
          end else begin
            dl_q[g]  <= dl_q[g-1];
            raw_q[g] <= raw_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      nrz_out  <= 1'b0;
      code_err <= 1'b0;
    end else begin
      nrz_out  <= drop_now ? 1'b0 : dl_q[DLY-1];
      code_err <= both || (viol && (!mode_hdb3 || !sub_ok));
    end
  end

  p_both_rails_err_r7: assert property (@(posedge clk) disable iff (rst)
    (smp.pos && smp.neg) |=> code_err);

  p_alt_no_err_r2: assert property (@(posedge clk) disable iff (rst)
    (one_mark && have_prev && (smp.pos != last_pos)) |=> !code_err);

endmodule

// File: rtl/ld_alarm.sv
module ld_alarm #(
  parameter int WIN  = 512,
  parameter int ZMIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic alarm_clr,
  input  logic line_zero,
  output logic alarm_flag
);

  localparam int WBITS = $clog2(WIN);
  localparam int ZBITS = $clog2(ZMIN + 1);

  logic [WBITS-1:0] wpos;
  logic [ZBITS-1:0] zcnt, zcnt_nx;
  logic             win_end;

  always_comb begin
    zcnt_nx = zcnt + ZBITS'(line_zero && (zcnt < ZBITS'(ZMIN)));
    win_end = (wpos == WBITS'(WIN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || alarm_clr) begin
      wpos       <= '0;
      zcnt       <= '0;
      alarm_flag <= 1'b0;
    end else begin
      if (win_end) begin
        wpos <= '0;
        zcnt <= '0;
        if (zcnt_nx < ZBITS'(ZMIN)) alarm_flag <= 1'b1;
      end else begin
        wpos <= wpos + 1'b1;
        zcnt <= zcnt_nx;
      end
    end
  end

  p_alarm_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !alarm_clr) |=> alarm_flag);

  p_alarm_clear_r9: assert property (@(posedge clk) disable iff (rst)
    alarm_clr |=> !alarm_flag);

  p_alarm_rise_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(alarm_flag)) |-> (wpos == '0));

endmodule

// File: rtl/line_decoder.sv
module line_decoder
  import line_dec_pkg::*;
#(
  parameter int SUB_LEN = 4,
  parameter int WIN     = 512,
  parameter int ZMIN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_hdb3,
  input  logic loop_en,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic lb_pos,
  input  logic lb_neg,
  input  logic alarm_clr,
  output logic nrz_out,
  output logic code_err,
  output logic alarm_flag
);

  rail_t ext_r, lb_r, smp;

  assign ext_r = '{pos: rx_pos, neg: rx_neg};
  assign lb_r  = '{pos: lb_pos, neg: lb_neg};

  ld_front u_front (
    .clk     (clk),
    .rst     (rst),
    .loop_en (loop_en),
    .ext_in  (ext_r),
    .lb_in   (lb_r),
    .smp     (smp)
  );

  ld_core #(.SUB_LEN(SUB_LEN)) u_core (
    .clk       (clk),
    .rst       (rst),
    .mode_hdb3 (mode_hdb3),
    .smp       (smp),
    .nrz_out   (nrz_out),
    .code_err  (code_err)
  );

  ld_alarm #(.WIN(WIN), .ZMIN(ZMIN)) u_alarm (
    .clk        (clk),
    .rst        (rst),
    .alarm_clr  (alarm_clr),
    .line_zero  (rail_empty(smp)),
    .alarm_flag (alarm_flag)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!nrz_out && !code_err && !alarm_flag));

endmodule

// File: tb/line_decoder_tb.sv
`timescale 1ns/1ps
module line_decoder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_hdb3 = 1'b0, loop_en = 1'b0;
  logic rx_pos = 1'b0, rx_neg = 1'b0, lb_pos = 1'b0, lb_neg = 1'b0;
  logic alarm_clr = 1'b0;
  logic nrz_out, code_err, alarm_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  line_decoder dut_i (
    .clk(clk), .rst(rst), .mode_hdb3(mode_hdb3), .loop_en(loop_en),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .lb_pos(lb_pos), .lb_neg(lb_neg),
    .alarm_clr(alarm_clr), .nrz_out(nrz_out), .code_err(code_err),
    .alarm_flag(alarm_flag)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // symbol codes: 0 none, 1 positive, 2 negative, 3 both rails
  task automatic put_sym(bit lb, int s);
    if (lb) begin
      lb_pos = (s == 1 || s == 3); lb_neg = (s == 2 || s == 3);
      rx_pos = 1'b1; rx_neg = 1'b1;
    end else begin
      rx_pos = (s == 1 || s == 3); rx_neg = (s == 2 || s == 3);
      lb_pos = 1'b1; lb_neg = 1'b1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; alarm_clr = 1'b0; put_sym(1'b0, 0); loop_en = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic run_seq(string req, bit hdb3, bit lb, int n,
                         int sym[16], int ed[16], int ee[16]);
    do_reset();
    mode_hdb3 = hdb3; loop_en = lb;
    for (int k = 0; k < n + 4; k++) begin
      put_sym(lb, (k < n) ? sym[k] : 0);
      step();
      if (k >= 1 && k - 1 < n) check(req, $sformatf("err[%0d]", k - 1), code_err, ee[k - 1]);
      if (k >= 4 && k - 4 < n) check(req, $sformatf("nrz[%0d]", k - 4), nrz_out, ed[k - 4]);
    end
    loop_en = 1'b0;
  endtask

  task automatic t_reset_r1();
    rst = 1'b1; put_sym(1'b0, 3);
    step(); step(); step();
    check("R1", "nrz", nrz_out, 0);
    check("R1", "err", code_err, 0);
    check("R1", "alarm", alarm_flag, 0);
  endtask

  task automatic t_ami_r2();
    run_seq("R2", 1'b0, 1'b0, 9,
      '{2,0,1,0,0,2,1,2,0, 0,0,0,0,0,0,0},
      '{1,0,1,0,0,1,1,1,0, 0,0,0,0,0,0,0},
      '{0,0,0,0,0,0,0,0,0, 0,0,0,0,0,0,0});
  endtask

  task automatic t_000v_r3();
    run_seq("R3", 1'b1, 1'b0, 7,
      '{1,0,0,0,1,2,0, 0,0,0,0,0,0,0,0,0},
      '{1,0,0,0,0,1,0, 0,0,0,0,0,0,0,0,0},
      '{0,0,0,0,0,0,0, 0,0,0,0,0,0,0,0,0});
  endtask

  task automatic t_b00v_r4();
    run_seq("R4", 1'b1, 1'b0, 7,
      '{1,2,0,0,2,1,0, 0,0,0,0,0,0,0,0,0},
      '{1,0,0,0,0,1,0, 0,0,0,0,0,0,0,0,0},
      '{0,0,0,0,0,0,0, 0,0,0,0,0,0,0,0,0});
  endtask

  task automatic t_ami_viol_r5();
    run_seq("R5", 1'b0, 1'b0, 6,
      '{1,0,0,1,2,0, 0,0,0,0,0,0,0,0,0,0},
      '{1,0,0,1,1,0, 0,0,0,0,0,0,0,0,0,0},
      '{0,0,0,1,0,0, 0,0,0,0,0,0,0,0,0,0});
  endtask

  task automatic t_bad_viol_r6();
    run_seq("R6", 1'b1, 1'b0, 6,
      '{1,0,1,2,2,0, 0,0,0,0,0,0,0,0,0,0},
      '{1,0,0,1,0,0, 0,0,0,0,0,0,0,0,0,0},
      '{0,0,1,0,1,0, 0,0,0,0,0,0,0,0,0,0});
  endtask

  task automatic t_both_r7();
    run_seq("R7", 1'b1, 1'b0, 5,
      '{1,3,2,0,1, 0,0,0,0,0,0,0,0,0,0,0},
      '{1,0,1,0,1, 0,0,0,0,0,0,0,0,0,0,0},
      '{0,1,0,0,0, 0,0,0,0,0,0,0,0,0,0,0});
  endtask

  task automatic t_loop_r10();
    run_seq("R10", 1'b1, 1'b1, 7,
      '{2,0,1,2,0,0,2, 0,0,0,0,0,0,0,0,0},
      '{1,0,1,0,0,0,0, 0,0,0,0,0,0,0,0,0},
      '{0,0,0,0,0,0,0, 0,0,0,0,0,0,0,0,0});
  endtask

  // alternating marks; zeros at offsets z0..z2 after the clear (-1 = unused)
  task automatic alarm_window(string req, int z0, int z1, int z2, int exp_end);
    bit pol = 1'b0;
    do_reset();
    mode_hdb3 = 1'b0;
    alarm_clr = 1'b1; put_sym(1'b0, 1); pol = 1'b1;
    step();                                   // edge X
    alarm_clr = 1'b0;
    for (int i = 1; i <= 512; i++) begin
      if (i == z0 || i == z1 || i == z2) put_sym(1'b0, 0);
      else begin put_sym(1'b0, pol ? 2 : 1); pol = ~pol; end
      step();
      if (i == 511) check(req, "alarm before window end", alarm_flag, 0);
    end
    check(req, "alarm at window end", alarm_flag, exp_end);
  endtask

  task automatic t_alarm_r8();
    alarm_window("R8", 10, 200, -1, 1);
    alarm_window("R8", 10, 200, 400, 0);
  endtask

  task automatic t_sticky_r9();
    alarm_window("R9", -1, -1, -1, 1);
    put_sym(1'b0, 0);
    for (int i = 0; i < 600; i++) step();
    check("R9", "alarm held on zero traffic", alarm_flag, 1);
    alarm_clr = 1'b1; step(); alarm_clr = 1'b0;
    check("R9", "alarm after clear", alarm_flag, 0);
    for (int i = 0; i < 600; i++) step();
    check("R9", "alarm stays low with zeros", alarm_flag, 0);
  endtask

  initial begin
    t_reset_r1();
    t_ami_r2();
    t_000v_r3();
    t_b00v_r4();
    t_ami_viol_r5();
    t_bad_viol_r6();
    t_both_r7();
    t_loop_r10();
    t_alarm_r8();
    t_sticky_r9();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule